// File: doc/BRIEF.md
# Register-File Datapath with Data Memory

This block is the execution core of a small processor: every clock cycle it carries out one control word. Two register numbers select operands from an eight-entry register file. The first operand feeds the ALU and also addresses an internal data memory. The second operand is either a register or an externally supplied constant, and it feeds the ALU and the memory write data. A single write-back bus returns either the ALU result or the memory read word to the register file.

Instruction fetch, decoding and sequencing are outside this block. A controller drives the control word each cycle. The ALU has no direct path to memory, so any memory update has to pass through a register: load, operate, then store.

The memory depth is set by the data width, so a register can address every word. It is written synchronously and read asynchronously. The ALU status flags are registered at each clock edge.

Top module: `rf_mem_datapath`

## Requirements
- R1: Synchronous active-high reset clears all eight registers and all four status flags to 0.
- R2: When `rf_we_i` is 1, the register numbered `wsel_i` takes the write-back value at the rising edge. When `rf_we_i` is 0, no register changes.
- R3: Register reads on `a_data_o`/`b_data_o` are asynchronous. A read of the register being written in the same cycle returns the old value until the edge, and the new value after it.
- R4: `bsel_const_i`=0 routes register port B to the ALU B input and the memory write data. `bsel_const_i`=1 routes `const_i` there instead.
- R5: `op_i` selects the ALU function. 00000 gives A, 00001 gives A+1, 00010 gives A+B, 00011 gives A+B+1, 00100 gives A+~B, 00101 gives A−B, 00110 gives A−1, 01000 gives A&B, 01010 gives A|B, 01100 gives A^B, 01110 gives ~A, 10000 gives B, 10100 gives B>>1 and 11000 gives B<<1. Every other code gives 0.
- R6: At each edge the flags capture the current ALU result, available from the next cycle. N is the result MSB and Z is set when the result is all-zero. For the arithmetic codes (00000–00110), C is the carry out of the MSB and V is the signed overflow. For all other codes, C=V=0.
- R7: When `mem_we_i` is 1, the memory word addressed by port A takes the B-side value at the edge. When `mem_we_i` is 0, memory is unchanged.
- R8: `wb_mem_i`=0 puts the ALU result on the write-back bus `wb_data_o`. `wb_mem_i`=1 puts the memory word addressed by port A there in the same cycle.
- R9: The three control words R3←M[R0], R3←R3+1, M[R0]←R3 leave M[R0] incremented by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| rf_we_i | input | 1 | Register write enable |
| wsel_i | input | 3 | Destination register number |
| asel_i | input | 3 | Register number for port A (ALU A, memory address) |
| bsel_i | input | 3 | Register number for port B |
| bsel_const_i | input | 1 | B-side source: 0 register, 1 constant |
| op_i | input | 5 | ALU function code |
| mem_we_i | input | 1 | Memory write enable |
| wb_mem_i | input | 1 | Write-back source: 0 ALU, 1 memory |
| const_i | input | 8 | External constant operand |
| a_data_o | output | 8 | Port A read value |
| b_data_o | output | 8 | Port B read value (before the constant mux) |
| wb_data_o | output | 8 | Write-back bus value |
| flag_v_o | output | 1 | Registered signed overflow flag |
| flag_c_o | output | 1 | Registered carry flag |
| flag_n_o | output | 1 | Registered negative flag |
| flag_z_o | output | 1 | Registered zero flag |

## Verification
Three results follow a control word at different times:
- `a_data_o`, `b_data_o` and `wb_data_o` are combinational. They are due in the cycle the word is applied, so the bench drives on the falling edge and samples them 1 ns later, before the next rising edge.
- Register and memory updates land at the rising edge and are checked through the read ports in a later cycle.
- Flags belong to the word that was present at the previous rising edge. The bench samples them 1 ns after that edge.

For the same-cycle write/read case, the bench samples both before and after the edge.

// File: rtl/rfdp_pkg.sv
package rfdp_pkg;
  localparam int unsigned OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_PASS_A = 5'b00000,
    OP_INC    = 5'b00001,
    OP_ADD    = 5'b00010,
    OP_ADDC   = 5'b00011,
    OP_ADD_NB = 5'b00100,
    OP_SUB    = 5'b00101,
    OP_DEC    = 5'b00110,
    OP_AND    = 5'b01000,
    OP_OR     = 5'b01010,
    OP_XOR    = 5'b01100,
    OP_NOT    = 5'b01110,
    OP_PASS_B = 5'b10000,
    OP_SHR    = 5'b10100,
    OP_SHL    = 5'b11000
  } alu_op_e;
endpackage

// File: rtl/rfdp_regfile.sv
module rfdp_regfile #(
  parameter int unsigned DW   = 8,
  parameter int unsigned NREG = 8,
  localparam int unsigned RW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [RW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [RW-1:0] raddr_a,
  input  logic [RW-1:0] raddr_b,
  output logic [DW-1:0] rdata_a,
  output logic [DW-1:0] rdata_b
);
  logic [DW-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we) begin
      regs[waddr] <= wdata;
    end
  end

  // Asynchronous reads: old contents are visible until the edge.
  assign rdata_a = regs[raddr_a];
  assign rdata_b = regs[raddr_b];

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (regs[0] == '0) && (regs[NREG-1] == '0));

  assert_write_lands_R2: assert property (@(posedge clk) disable iff (rst)
    we |=> regs[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/rfdp_alu.sv
module rfdp_alu
  import rfdp_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic [DW-1:0]   a,
  input  logic [DW-1:0]   b,
  input  logic [OP_W-1:0] op,
  output logic [DW-1:0]   f,
  output logic            c,
  output logic            v
);
  logic [DW-1:0] y;
  logic          cin;
  logic          arith;
  logic [DW:0]   sum;

  // Adder operand selection for the arithmetic group.
  always_comb begin
    y     = '0;
    cin   = 1'b0;
    arith = 1'b1;
    case (op)
      OP_PASS_A: ;
      OP_INC:    cin = 1'b1;
      OP_ADD:    y = b;
      OP_ADDC:   begin y = b;  cin = 1'b1; end
      OP_ADD_NB: y = ~b;
      OP_SUB:    begin y = ~b; cin = 1'b1; end
      OP_DEC:    y = '1;
      default:   arith = 1'b0;
    endcase
  end

  assign sum = {1'b0, a} + {1'b0, y} + (DW+1)'(cin);

  always_comb begin
    c = 1'b0;
    v = 1'b0;
    if (arith) begin
      f = sum[DW-1:0];
      c = sum[DW];
      v = (a[DW-1] == y[DW-1]) && (sum[DW-1] != a[DW-1]);
    end else begin
      case (op)
        OP_AND:    f = a & b;
        OP_OR:     f = a | b;
        OP_XOR:    f = a ^ b;
        OP_NOT:    f = ~a;
        OP_PASS_B: f = b;
        OP_SHR:    f = b >> 1;
        OP_SHL:    f = b << 1;
        default:   f = '0;
      endcase
    end
  end
endmodule

// File: rtl/rfdp_ram.sv
module rfdp_ram #(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 8,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];

  assert_mem_write_R7: assert property (@(posedge clk) disable iff (rst)
    we |=> mem[$past(addr)] == $past(wdata));

  assert_mem_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !we |=> mem[$past(addr)] == $past(rdata));
endmodule

// File: rtl/rf_mem_datapath.sv
module rf_mem_datapath
  import rfdp_pkg::*;
#(
  parameter int unsigned DW     = 8,
  parameter int unsigned NREG   = 8,
  parameter int unsigned MEM_AW = DW,
  localparam int unsigned RW    = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rf_we_i,
  input  logic [RW-1:0]   wsel_i,
  input  logic [RW-1:0]   asel_i,
  input  logic [RW-1:0]   bsel_i,
  input  logic            bsel_const_i,
  input  logic [OP_W-1:0] op_i,
  input  logic            mem_we_i,
  input  logic            wb_mem_i,
  input  logic [DW-1:0]   const_i,
  output logic [DW-1:0]   a_data_o,
  output logic [DW-1:0]   b_data_o,
  output logic [DW-1:0]   wb_data_o,
  output logic            flag_v_o,
  output logic            flag_c_o,
  output logic            flag_n_o,
  output logic            flag_z_o
);
  logic [DW-1:0] b_side;
  logic [DW-1:0] alu_f;
  logic          alu_c;
  logic          alu_v;
  logic [DW-1:0] mem_q;

  rfdp_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .we      (rf_we_i),
    .waddr   (wsel_i),
    .wdata   (wb_data_o),
    .raddr_a (asel_i),
    .raddr_b (bsel_i),
    .rdata_a (a_data_o),
    .rdata_b (b_data_o)
  );

  assign b_side = bsel_const_i ? const_i : b_data_o;

  rfdp_alu #(.DW(DW)) u_alu (
    .a  (a_data_o),
    .b  (b_side),
    .op (op_i),
    .f  (alu_f),
    .c  (alu_c),
    .v  (alu_v)
  );

  // Memory address comes only from register port A.
  rfdp_ram #(.DW(DW), .AW(MEM_AW)) u_ram (
    .clk   (clk),
    .rst   (rst),
    .we    (mem_we_i),
    .addr  (a_data_o[MEM_AW-1:0]),
    .wdata (b_side),
    .rdata (mem_q)
  );

  assign wb_data_o = wb_mem_i ? mem_q : alu_f;

  always_ff @(posedge clk) begin
    if (rst) begin
      {flag_v_o, flag_c_o, flag_n_o, flag_z_o} <= '0;
    end else begin
      flag_v_o <= alu_v;
      flag_c_o <= alu_c;
      flag_n_o <= alu_f[DW-1];
      flag_z_o <= (alu_f == '0);
    end
  end

  assert_add_sum_R5: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_ADD) |->
      alu_f == DW'(a_data_o + (bsel_const_i ? const_i : b_data_o)));

  assert_zero_flag_R6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> flag_z_o == ($past(alu_f) == '0));
endmodule

// File: tb/rf_mem_datapath_bench.sv
module rf_mem_datapath_bench;
  import rfdp_pkg::*;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rf_we, bconst, mem_we, wb_mem;
  logic [2:0] wsel, asel, bsel;
  logic [4:0] op;
  logic [7:0] kval;
  logic [7:0] a_data, b_data, wb_data;
  logic       fv, fc, fn, fz;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rf_mem_datapath u_rf_mem_datapath (
    .clk(clk), .rst(rst), .rf_we_i(rf_we), .wsel_i(wsel), .asel_i(asel),
    .bsel_i(bsel), .bsel_const_i(bconst), .op_i(op), .mem_we_i(mem_we),
    .wb_mem_i(wb_mem), .const_i(kval), .a_data_o(a_data), .b_data_o(b_data),
    .wb_data_o(wb_data), .flag_v_o(fv), .flag_c_o(fc), .flag_n_o(fn),
    .flag_z_o(fz)
  );

  typedef struct packed {
    logic       we;
    logic [2:0] d, a, b;
    logic       mb;
    logic [4:0] fs;
    logic       mw, md;
    logic [7:0] k, exp_a, exp_wb;
    logic [3:0] exp_vcnz;
  } step_t;

  localparam step_t STEPS [13] = '{
    '{1'b1, 3'd0, 3'd0, 3'd0, 1'b1, 5'b10000, 1'b0, 1'b0, 8'h10, 8'h00, 8'h10, 4'b0000}, // R4 R2
    '{1'b1, 3'd1, 3'd0, 3'd0, 1'b1, 5'b10000, 1'b0, 1'b0, 8'h7F, 8'h10, 8'h7F, 4'b0000},
    '{1'b1, 3'd2, 3'd1, 3'd0, 1'b1, 5'b00001, 1'b0, 1'b0, 8'h00, 8'h7F, 8'h80, 4'b1010}, // R6 overflow
    '{1'b1, 3'd3, 3'd0, 3'd0, 1'b1, 5'b10000, 1'b0, 1'b0, 8'hFF, 8'h10, 8'hFF, 4'b0010},
    '{1'b1, 3'd4, 3'd3, 3'd3, 1'b0, 5'b00010, 1'b0, 1'b0, 8'h00, 8'hFF, 8'hFE, 4'b0110}, // R6 carry
    '{1'b1, 3'd5, 3'd1, 3'd1, 1'b0, 5'b00101, 1'b0, 1'b0, 8'h00, 8'h7F, 8'h00, 4'b0101}, // R6 zero
    '{1'b0, 3'd0, 3'd0, 3'd1, 1'b0, 5'b00000, 1'b1, 1'b0, 8'h00, 8'h10, 8'h10, 4'b0000}, // R7 reg data
    '{1'b0, 3'd0, 3'd2, 3'd0, 1'b1, 5'b10000, 1'b1, 1'b0, 8'h5A, 8'h80, 8'h5A, 4'b0000}, // R7 const data
    '{1'b1, 3'd3, 3'd0, 3'd0, 1'b0, 5'b00000, 1'b0, 1'b1, 8'h00, 8'h10, 8'h7F, 4'b0000}, // R9 load
    '{1'b1, 3'd3, 3'd3, 3'd0, 1'b0, 5'b00001, 1'b0, 1'b0, 8'h00, 8'h7F, 8'h80, 4'b1010}, // R9 increment
    '{1'b0, 3'd0, 3'd0, 3'd3, 1'b0, 5'b00000, 1'b1, 1'b0, 8'h00, 8'h10, 8'h10, 4'b0000}, // R9 store
    '{1'b1, 3'd6, 3'd0, 3'd0, 1'b0, 5'b00000, 1'b0, 1'b1, 8'h00, 8'h10, 8'h80, 4'b0000}, // R9 R8 readback
    '{1'b1, 3'd7, 3'd2, 3'd0, 1'b0, 5'b00000, 1'b0, 1'b1, 8'h00, 8'h80, 8'h5A, 4'b0010}  // R8
  };

  typedef struct packed {
    logic [4:0] fs;
    logic [7:0] exp;
  } aluv_t;

  localparam aluv_t ALUV [10] = '{
    '{5'b01000, 8'h00}, '{5'b01010, 8'hFF}, '{5'b01100, 8'hFF},
    '{5'b01110, 8'h80}, '{5'b10100, 8'h40}, '{5'b11000, 8'h00},
    '{5'b00110, 8'h7E}, '{5'b00100, 8'hFE}, '{5'b00011, 8'h00},
    '{5'b11111, 8'h00}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic we, input logic [2:0] d, input logic [2:0] a,
                       input logic [2:0] b, input logic mb, input logic [4:0] fs,
                       input logic mw, input logic md, input logic [7:0] k);
    rf_we = we; wsel = d; asel = a; bsel = b; bconst = mb;
    op = fs; mem_we = mw; wb_mem = md; kval = k;
  endtask

  task automatic idle();
    drive(1'b0, 3'd0, 3'd0, 3'd0, 1'b0, 5'b00000, 1'b0, 1'b0, 8'h00);
  endtask

  task automatic check_all_zero(input string tag);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      drive(1'b0, 3'd0, 3'(i), 3'(i), 1'b0, 5'b00000, 1'b0, 1'b0, 8'h00);
      #1;
      chk(tag, a_data, 8'h00);
      chk(tag, b_data, 8'h00);
    end
  endtask

  initial begin
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1 flags after reset", {4'h0, fv, fc, fn, fz}, 8'h00);
    check_all_zero("R1 regs after reset");

    // Table walk: combinational outputs before the edge, flags after it.
    foreach (STEPS[i]) begin
      @(negedge clk);
      drive(STEPS[i].we, STEPS[i].d, STEPS[i].a, STEPS[i].b, STEPS[i].mb,
            STEPS[i].fs, STEPS[i].mw, STEPS[i].md, STEPS[i].k);
      #1;
      chk($sformatf("R3 a_data step %0d", i), a_data, STEPS[i].exp_a);
      chk($sformatf("R8 wb_data step %0d", i), wb_data, STEPS[i].exp_wb);
      @(posedge clk);
      #1;
      chk($sformatf("R6 flags step %0d", i), {4'h0, fv, fc, fn, fz}, {4'h0, STEPS[i].exp_vcnz});
    end

    // R5: remaining ALU codes with A=R1 (7F), B=R2 (80), no writes.
    foreach (ALUV[i]) begin
      @(negedge clk);
      drive(1'b0, 3'd0, 3'd1, 3'd2, 1'b0, ALUV[i].fs, 1'b0, 1'b0, 8'h00);
      #1;
      chk($sformatf("R5 op %b", ALUV[i].fs), wb_data, ALUV[i].exp);
      if (ALUV[i].fs == 5'b00011) begin
        @(posedge clk);
        #1;
        chk("R6 flags A+B+1 wrap", {4'h0, fv, fc, fn, fz}, 8'h05);
      end
    end

    // R4: constant vs register on the B side; b_data_o stays the register.
    @(negedge clk);
    drive(1'b0, 3'd0, 3'd0, 3'd1, 1'b1, 5'b10000, 1'b0, 1'b0, 8'h21);
    #1;
    chk("R4 const selected", wb_data, 8'h21);
    chk("R4 b port unaffected", b_data, 8'h7F);
    @(negedge clk);
    bconst = 1'b0;
    #1;
    chk("R4 register selected", wb_data, 8'h7F);

    // R7: MW=0 with a constant on the B side must not touch M[0x10] (0x80).
    @(negedge clk);
    drive(1'b0, 3'd0, 3'd0, 3'd0, 1'b1, 5'b10000, 1'b0, 1'b1, 8'hEE);
    #1;
    chk("R7 read before", wb_data, 8'h80);
    @(posedge clk);
    #1;
    chk("R7 unchanged when MW=0", wb_data, 8'h80);

    // R3: write and read the same register in one cycle.
    @(negedge clk);
    drive(1'b1, 3'd5, 3'd5, 3'd5, 1'b1, 5'b10000, 1'b0, 1'b0, 8'h33);
    #1;
    chk("R3 old value on A before edge", a_data, 8'h00);
    chk("R3 old value on B before edge", b_data, 8'h00);
    @(posedge clk);
    #1;
    chk("R3 new value on A after edge", a_data, 8'h33);
    chk("R3 new value on B after edge", b_data, 8'h33);

    // R2: WR=0 leaves the register alone.
    @(negedge clk);
    drive(1'b0, 3'd5, 3'd5, 3'd5, 1'b1, 5'b10000, 1'b0, 1'b0, 8'h44);
    @(posedge clk);
    #1;
    chk("R2 no write when WR=0", a_data, 8'h33);

    // R1: reset in the middle of operation.
    @(negedge clk);
    drive(1'b0, 3'd0, 3'd1, 3'd2, 1'b0, 5'b00010, 1'b0, 1'b0, 8'h00);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1 flags cleared by reset", {4'h0, fv, fc, fn, fz}, 8'h00);
    check_all_zero("R1 regs cleared by reset");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule